// File: doc/BRIEF.md
# Event-Driven Multi-Kernel Convolution Unit

This unit turns a sparse stream of address events into convolved output events. Each input word names a pixel position and picks one of the stored kernels. The unit walks that kernel tap by tap and adds each signed weight into a field of leaky integrate-and-fire accumulators placed around the event position. An accumulator that reaches either threshold emits an output event carrying its position and a polarity bit, then returns to zero. There are no frames and no timestamps: only the order of arrival matters.

Every kernel has its own height, width and anchor offset, so one array can host many different filters. A leak pulse starts a sweep over the whole array that moves each accumulator one step toward zero. This makes old activity fade, so only features whose events arrive close together in time reach threshold. Output events wait in a small FIFO. The walk over the kernel pauses while that FIFO is full.

Top module: `ev_conv_unit`

## Requirements
- R1: The 5-bit field `ev_k_i` picks which of 32 stored kernels is added for that event. An unwritten kernel has all weights zero and so changes nothing.
- R2: A kernel covers `kg_rows_i`+1 rows and `kg_cols_i`+1 columns, each from 1 to 8. Every tap is applied exactly once per event.
- R3: Tap (row r, column c) lands on pixel (x + c - ox, y + r - oy). Here ox and oy are the kernel's 6-bit two's-complement offsets `kg_ox_i`/`kg_oy_i`, and x and y are the event position.
- R4: A tap whose target column or row lies outside 0..31 is skipped. It never wraps onto another pixel.
- R5: Weights are 4-bit two's complement and accumulators are 8-bit signed. When the new sum is >= +32, the pixel emits an event with `oe_pos_o`=1. When the sum is <= -32, it emits one with `oe_pos_o`=0. In both cases the accumulator becomes 0; otherwise it holds the sum.
- R6: Taps are visited row by row with columns ascending, one per cycle, and output events leave in that order. With the FIFO not full, an event using an HxW kernel holds `ev_ready_o` low for exactly H*W cycles after it is accepted.
- R7: A one-cycle `leak_i` pulse moves every nonzero accumulator one step toward zero. This happens before the next input event is accepted.
- R8: A leak pulse given while idle holds `ev_ready_o` low for exactly 1025 cycles: one cycle of request plus one per pixel.
- R9: The output FIFO holds 4 events. While it is full the kernel walk pauses and `ev_ready_o` stays low, and no output event is lost or reordered.
- R10: After reset, `ev_ready_o` is 1, `oe_valid_o` is 0, all accumulators are 0, all weights are 0, and every kernel is 1x1 with zero offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kw_valid_i | input | 1 | Write one kernel weight |
| kw_sel_i | input | 5 | Kernel being written |
| kw_row_i | input | 3 | Weight row |
| kw_col_i | input | 3 | Weight column |
| kw_data_i | input | 4 | Signed weight |
| kg_valid_i | input | 1 | Write kernel geometry |
| kg_sel_i | input | 5 | Kernel whose geometry is written |
| kg_rows_i | input | 3 | Rows minus one |
| kg_cols_i | input | 3 | Columns minus one |
| kg_ox_i | input | 6 | Signed column anchor offset |
| kg_oy_i | input | 6 | Signed row anchor offset |
| ev_valid_i | input | 1 | Input event valid |
| ev_ready_o | output | 1 | Input event accepted when high with valid |
| ev_x_i | input | 5 | Event column |
| ev_y_i | input | 5 | Event row |
| ev_k_i | input | 5 | Kernel select |
| leak_i | input | 1 | Leak request pulse |
| oe_valid_o | output | 1 | Output event valid |
| oe_ready_i | input | 1 | Output event taken |
| oe_x_o | output | 5 | Firing pixel column |
| oe_y_o | output | 5 | Firing pixel row |
| oe_pos_o | output | 1 | 1 = positive threshold, 0 = negative |

## Verification
The hardest state to reach is a kernel walk that stalls partway through an event because the output FIFO has filled. Reaching it needs many pixels to cross threshold during one walk while the consumer refuses output. The bench primes an 8x8 field with four sub-threshold events and holds `oe_ready_i` low. A fifth event then fires all 64 pixels. The bench checks that input stays blocked, then releases the consumer and compares every event against a behavioural model of the accumulators. Clipping at both corners and leak decay that just prevents a fire are reached through chosen offsets and counted event sequences.

// File: rtl/ev_conv_pkg.sv
package ev_conv_pkg;
  localparam int unsigned GRID   = 32;
  localparam int unsigned K_MAX  = 8;
  localparam int unsigned N_KERN = 32;
  localparam int unsigned ACC_W  = 8;
  localparam int unsigned WT_W   = 4;
  localparam int unsigned XW     = $clog2(GRID);
  localparam int unsigned KW     = $clog2(K_MAX);
  localparam int unsigned SELW   = $clog2(N_KERN);
  localparam int unsigned OFFW   = XW + 1;
  localparam int unsigned SW     = XW + 3;

  typedef struct packed {
    logic [KW-1:0]   h_last;
    logic [KW-1:0]   w_last;
    logic [OFFW-1:0] ox;
    logic [OFFW-1:0] oy;
  } geom_t;

  typedef struct packed {
    logic [XW-1:0] x;
    logic [XW-1:0] y;
    logic          pos;
  } oev_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_LEAK} st_e;
  typedef enum logic [1:0] {PX_NOP, PX_ADD, PX_LEAK} px_op_e;
endpackage

// File: rtl/ev_conv_kstore.sv
module ev_conv_kstore
  import ev_conv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wt_we_i,
  input  logic [SELW-1:0] wt_sel_i,
  input  logic [KW-1:0]   wt_row_i,
  input  logic [KW-1:0]   wt_col_i,
  input  logic [WT_W-1:0] wt_data_i,
  input  logic            gm_we_i,
  input  logic [SELW-1:0] gm_sel_i,
  input  geom_t           gm_i,
  input  logic [SELW-1:0] gm_rd_i,
  output geom_t           gm_o,
  input  logic [SELW-1:0] wt_rd_sel_i,
  input  logic [KW-1:0]   wt_rd_row_i,
  input  logic [KW-1:0]   wt_rd_col_i,
  output logic [WT_W-1:0] wt_o
);
  localparam int unsigned NW = N_KERN * K_MAX * K_MAX;

  logic [WT_W-1:0] wmem [NW];
  geom_t           gmem [N_KERN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NW); i++) wmem[i] <= '0;
    end else if (wt_we_i) begin
      wmem[{wt_sel_i, wt_row_i, wt_col_i}] <= wt_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_KERN); i++) gmem[i] <= '0;
    end else if (gm_we_i) begin
      gmem[gm_sel_i] <= gm_i;
    end
  end

  assign wt_o = wmem[{wt_rd_sel_i, wt_rd_row_i, wt_rd_col_i}];
  assign gm_o = gmem[gm_rd_i];
endmodule

// File: rtl/ev_conv_pixels.sv
module ev_conv_pixels
  import ev_conv_pkg::*;
#(
  parameter int TH_POS = 32,
  parameter int TH_NEG = -32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  px_op_e          op_i,
  input  logic [2*XW-1:0] addr_i,
  input  logic [WT_W-1:0] wt_i,
  output logic            fire_o,
  output logic            pos_o
);
  localparam int unsigned NPIX = GRID * GRID;

  logic signed [ACC_W-1:0] mem [NPIX];
  logic signed [ACC_W-1:0] cur, leaked;
  logic signed [ACC_W:0]   sum;
  logic                    hit_pos, hit_neg;

  assign cur     = mem[addr_i];
  assign sum     = $signed({cur[ACC_W-1], cur})
                 + $signed({{(ACC_W+1-WT_W){wt_i[WT_W-1]}}, wt_i});
  assign hit_pos = int'(sum) >= TH_POS;
  assign hit_neg = int'(sum) <= TH_NEG;
  assign fire_o  = (op_i == PX_ADD) && (hit_pos || hit_neg);
  assign pos_o   = hit_pos;

  // one step toward zero
  assign leaked = cur[ACC_W-1] ? cur + ACC_W'(1)
                : (cur != '0)  ? cur - ACC_W'(1) : cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPIX); i++) mem[i] <= '0;
    end else begin
      unique case (op_i)
        PX_ADD:  mem[addr_i] <= fire_o ? '0 : sum[ACC_W-1:0];
        PX_LEAK: mem[addr_i] <= leaked;
        default: ;
      endcase
    end
  end

  p_fire_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (mem[$past(addr_i)] == '0));
endmodule

// File: rtl/ev_conv_ofifo.sv
module ev_conv_ofifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_pop;

  assign valid_o = cnt_q != '0;
  assign full_o  = cnt_q == (AW+1)'(DEPTH);
  assign data_o  = mem_q[rp_q];
  assign do_pop  = pop_i && valid_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (do_pop) rp_q <= nxt(rp_q);
      if (push_i && !do_pop)      cnt_q <= cnt_q + (AW+1)'(1);
      else if (!push_i && do_pop) cnt_q <= cnt_q - (AW+1)'(1);
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/ev_conv_unit.sv
module ev_conv_unit
  import ev_conv_pkg::*;
#(
  parameter int          TH_POS      = 32,
  parameter int          TH_NEG      = -32,
  parameter int unsigned OFIFO_DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            kw_valid_i,
  input  logic [SELW-1:0] kw_sel_i,
  input  logic [KW-1:0]   kw_row_i,
  input  logic [KW-1:0]   kw_col_i,
  input  logic [WT_W-1:0] kw_data_i,
  input  logic            kg_valid_i,
  input  logic [SELW-1:0] kg_sel_i,
  input  logic [KW-1:0]   kg_rows_i,
  input  logic [KW-1:0]   kg_cols_i,
  input  logic [OFFW-1:0] kg_ox_i,
  input  logic [OFFW-1:0] kg_oy_i,
  input  logic            ev_valid_i,
  output logic            ev_ready_o,
  input  logic [XW-1:0]   ev_x_i,
  input  logic [XW-1:0]   ev_y_i,
  input  logic [SELW-1:0] ev_k_i,
  input  logic            leak_i,
  output logic            oe_valid_o,
  input  logic            oe_ready_i,
  output logic [XW-1:0]   oe_x_o,
  output logic [XW-1:0]   oe_y_o,
  output logic            oe_pos_o
);
  localparam int unsigned OEW = $bits(oev_t);

  st_e              st_q;
  logic [XW-1:0]    ex_q, ey_q;
  logic [SELW-1:0]  ek_q;
  geom_t            gm_q, gm_rd, gm_wr;
  logic [KW-1:0]    row_q, col_q;
  logic [2*XW-1:0]  lidx_q;
  logic             leak_pend_q;

  logic signed [SW-1:0] tx, ty;
  logic                 in_x, in_y, fifo_full, step, last_col, last_row;
  logic                 px_fire, px_pos;
  logic [WT_W-1:0]      wt;
  px_op_e               px_op;
  logic [2*XW-1:0]      px_addr;
  oev_t                 push_ev, head_ev;
  logic [OEW-1:0]       head_raw;

  assign gm_wr = '{h_last: kg_rows_i, w_last: kg_cols_i, ox: kg_ox_i, oy: kg_oy_i};

  ev_conv_kstore u_kstore (
    .clk_i, .rst_ni,
    .wt_we_i    (kw_valid_i),
    .wt_sel_i   (kw_sel_i),
    .wt_row_i   (kw_row_i),
    .wt_col_i   (kw_col_i),
    .wt_data_i  (kw_data_i),
    .gm_we_i    (kg_valid_i),
    .gm_sel_i   (kg_sel_i),
    .gm_i       (gm_wr),
    .gm_rd_i    (ev_k_i),
    .gm_o       (gm_rd),
    .wt_rd_sel_i(ek_q),
    .wt_rd_row_i(row_q),
    .wt_rd_col_i(col_q),
    .wt_o       (wt)
  );

  // target pixel of the current tap, signed so clipping sees negatives
  assign tx = SW'(ex_q) + SW'(col_q) - {{(SW-OFFW){gm_q.ox[OFFW-1]}}, gm_q.ox};
  assign ty = SW'(ey_q) + SW'(row_q) - {{(SW-OFFW){gm_q.oy[OFFW-1]}}, gm_q.oy};
  assign in_x = !tx[SW-1] && (tx[SW-2:0] < (SW-1)'(GRID));
  assign in_y = !ty[SW-1] && (ty[SW-2:0] < (SW-1)'(GRID));

  assign step     = (st_q == ST_SCAN) && !fifo_full;
  assign last_col = col_q == gm_q.w_last;
  assign last_row = row_q == gm_q.h_last;
  assign px_op    = (step && in_x && in_y) ? PX_ADD
                  : (st_q == ST_LEAK)      ? PX_LEAK : PX_NOP;
  assign px_addr  = (st_q == ST_LEAK) ? lidx_q : {ty[XW-1:0], tx[XW-1:0]};

  ev_conv_pixels #(.TH_POS(TH_POS), .TH_NEG(TH_NEG)) u_pixels (
    .clk_i, .rst_ni,
    .op_i  (px_op),
    .addr_i(px_addr),
    .wt_i  (wt),
    .fire_o(px_fire),
    .pos_o (px_pos)
  );

  assign push_ev = '{x: tx[XW-1:0], y: ty[XW-1:0], pos: px_pos};

  ev_conv_ofifo #(.DEPTH(OFIFO_DEPTH), .W(OEW)) u_ofifo (
    .clk_i, .rst_ni,
    .push_i (px_fire),
    .data_i (push_ev),
    .pop_i  (oe_ready_i),
    .data_o (head_raw),
    .valid_o(oe_valid_o),
    .full_o (fifo_full)
  );

  assign head_ev    = oev_t'(head_raw);
  assign oe_x_o     = head_ev.x;
  assign oe_y_o     = head_ev.y;
  assign oe_pos_o   = head_ev.pos;
  assign ev_ready_o = (st_q == ST_IDLE) && !leak_pend_q && !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ex_q        <= '0;
      ey_q        <= '0;
      ek_q        <= '0;
      gm_q        <= '0;
      row_q       <= '0;
      col_q       <= '0;
      lidx_q      <= '0;
      leak_pend_q <= 1'b0;
    end else begin
      leak_pend_q <= leak_i | (leak_pend_q & (st_q != ST_IDLE));
      unique case (st_q)
        ST_IDLE: begin
          if (leak_pend_q) begin
            st_q   <= ST_LEAK;
            lidx_q <= '0;
          end else if (ev_valid_i && ev_ready_o) begin
            ex_q  <= ev_x_i;
            ey_q  <= ev_y_i;
            ek_q  <= ev_k_i;
            gm_q  <= gm_rd;
            row_q <= '0;
            col_q <= '0;
            st_q  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (step) begin
            if (last_col) begin
              col_q <= '0;
              if (last_row) st_q <= ST_IDLE;
              else          row_q <= row_q + KW'(1);
            end else begin
              col_q <= col_q + KW'(1);
            end
          end
        end
        ST_LEAK: begin
          lidx_q <= lidx_q + (2*XW)'(1);
          if (&lidx_q) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_accept_starts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_ready_o) |=> (st_q == ST_SCAN && row_q == '0 && col_q == '0));
  p_tap_in_kernel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN) |-> (row_q <= gm_q.h_last && col_q <= gm_q.w_last));
  p_leak_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEAK) |-> !ev_ready_o);
  p_leak_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leak_pend_q && st_q == ST_IDLE) |=> (st_q == ST_LEAK));
  p_full_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full |-> !ev_ready_o);
endmodule

// File: tb/ev_conv_unit_tb_top.sv
module ev_conv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int G = 32;
  localparam int THP = 32;
  localparam int THN = -32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       kw_valid_i = 1'b0;
  logic [4:0] kw_sel_i = '0;
  logic [2:0] kw_row_i = '0;
  logic [2:0] kw_col_i = '0;
  logic [3:0] kw_data_i = '0;
  logic       kg_valid_i = 1'b0;
  logic [4:0] kg_sel_i = '0;
  logic [2:0] kg_rows_i = '0;
  logic [2:0] kg_cols_i = '0;
  logic [5:0] kg_ox_i = '0;
  logic [5:0] kg_oy_i = '0;
  logic       ev_valid_i = 1'b0;
  logic       ev_ready_o;
  logic [4:0] ev_x_i = '0;
  logic [4:0] ev_y_i = '0;
  logic [4:0] ev_k_i = '0;
  logic       leak_i = 1'b0;
  logic       oe_valid_o;
  logic       oe_ready_i = 1'b0;
  logic [4:0] oe_x_o;
  logic [4:0] oe_y_o;
  logic       oe_pos_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ev_conv_unit dut_i (.*);

  int acc [G][G];
  int kwm [32][8][8];
  int kh [32], kwd [32], kox [32], koy [32];
  logic [10:0] exp_q [$];
  int total = 0, bad = 0, cyc = 0;
  bit bp_hold = 1'b0;
  string req = "R10";

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // consumer: periodic gaps, full hold under bp_hold
  initial forever begin
    @(posedge clk_i); #1;
    oe_ready_i = !bp_hold && (cyc % 4 != 3);
    cyc++;
  end

  // output monitor against model queue
  always @(negedge clk_i) begin
    if (rst_ni && oe_valid_o && oe_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, {req, " unexpected event"}, int'({oe_x_o, oe_y_o, oe_pos_o}), -1);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({oe_x_o, oe_y_o, oe_pos_o} == e, req, int'({oe_x_o, oe_y_o, oe_pos_o}), int'(e));
      end
    end
  end

  task automatic set_wt(input int k, input int r, input int c, input int v);
    kw_valid_i = 1'b1; kw_sel_i = 5'(k); kw_row_i = 3'(r); kw_col_i = 3'(c); kw_data_i = 4'(v);
    tick();
    kw_valid_i = 1'b0;
    kwm[k][r][c] = v;
  endtask

  task automatic set_geom(input int k, input int rows, input int cols, input int ox, input int oy);
    kg_valid_i = 1'b1; kg_sel_i = 5'(k); kg_rows_i = 3'(rows - 1); kg_cols_i = 3'(cols - 1);
    kg_ox_i = 6'(ox); kg_oy_i = 6'(oy);
    tick();
    kg_valid_i = 1'b0;
    kh[k] = rows; kwd[k] = cols; kox[k] = ox; koy[k] = oy;
  endtask

  task automatic fill_kernel(input int k, input int rows, input int cols, input int ox, input int oy, input int v);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) set_wt(k, r, c, v);
    set_geom(k, rows, cols, ox, oy);
  endtask

  task automatic model_event(input int x, input int y, input int k);
    for (int r = 0; r < kh[k]; r++)
      for (int c = 0; c < kwd[k]; c++) begin
        int px, py, s;
        px = x + c - kox[k];
        py = y + r - koy[k];
        if (px >= 0 && px < G && py >= 0 && py < G) begin
          s = acc[px][py] + kwm[k][r][c];
          if (s >= THP) begin exp_q.push_back({5'(px), 5'(py), 1'b1}); acc[px][py] = 0; end
          else if (s <= THN) begin exp_q.push_back({5'(px), 5'(py), 1'b0}); acc[px][py] = 0; end
          else acc[px][py] = s;
        end
      end
  endtask

  task automatic send_ev(input int x, input int y, input int k);
    bit a;
    ev_valid_i = 1'b1; ev_x_i = 5'(x); ev_y_i = 5'(y); ev_k_i = 5'(k);
    do begin
      @(negedge clk_i); a = ev_ready_o;
      tick();
    end while (!a);
    ev_valid_i = 1'b0;
    model_event(x, y, k);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    forever begin
      @(negedge clk_i);
      if (ev_ready_o) break;
      n++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) tick();
    repeat (20) tick();
    chk(exp_q.size() == 0, {req, " R9 drain"}, exp_q.size(), 0);
  endtask

  task automatic do_leak();
    int n;
    leak_i = 1'b1;
    tick();
    leak_i = 1'b0;
    busy_len(n);
    chk(n == G * G + 1, "R8 leak stall", n, G * G + 1);
    for (int x = 0; x < G; x++)
      for (int y = 0; y < G; y++)
        if (acc[x][y] > 0) acc[x][y]--; else if (acc[x][y] < 0) acc[x][y]++;
    tick();
  endtask

  initial begin
    int n;
    for (int x = 0; x < G; x++) for (int y = 0; y < G; y++) acc[x][y] = 0;
    for (int k = 0; k < 32; k++) begin
      kh[k] = 1; kwd[k] = 1; kox[k] = 0; koy[k] = 0;
      for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) kwm[k][r][c] = 0;
    end
    repeat (3) tick();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ev_ready_o == 1'b1, "R10 ready", int'(ev_ready_o), 1);
    chk(oe_valid_o == 1'b0, "R10 valid", int'(oe_valid_o), 0);
    tick();

    // R1 R5: selection, both thresholds, zero kernel
    req = "R1 R5 select/threshold";
    fill_kernel(4, 1, 1, 0, 0, 7);
    fill_kernel(3, 1, 1, 0, 0, -8);
    for (int i = 0; i < 5; i++) send_ev(5, 6, 4);
    for (int i = 0; i < 4; i++) send_ev(5, 6, 3);
    for (int i = 0; i < 6; i++) send_ev(9, 9, 0);
    for (int i = 0; i < 5; i++) send_ev(9, 9, 4);
    drain();

    // R6 R2: tap count sets busy time
    req = "R6 R2 timing";
    fill_kernel(6, 3, 4, 0, 0, 1);
    send_ev(15, 15, 6);
    busy_len(n);
    chk(n == 12, "R6 3x4 busy", n, 12);
    fill_kernel(7, 8, 1, 0, 0, 1);
    send_ev(2, 20, 7);
    busy_len(n);
    chk(n == 8, "R2 8x1 busy", n, 8);
    drain();

    // R3: signed anchor offsets, varied weights
    req = "R3 offset";
    for (int r = 0; r < 2; r++) for (int c = 0; c < 3; c++) set_wt(9, r, c, r * 3 + c + 2);
    set_geom(9, 2, 3, -3, 2);
    for (int i = 0; i < 6; i++) send_ev(10, 10, 9);
    drain();

    // R4: clipping at both corners
    req = "R4 clip";
    fill_kernel(10, 8, 8, 3, 3, 7);
    for (int i = 0; i < 5; i++) send_ev(0, 0, 10);
    for (int i = 0; i < 5; i++) send_ev(31, 31, 10);
    drain();

    // R7: leak just prevents fire, both signs
    req = "R7 leak";
    for (int i = 0; i < 4; i++) send_ev(20, 20, 4);
    for (int i = 0; i < 3; i++) send_ev(22, 3, 3);
    drain();
    for (int i = 0; i < 4; i++) do_leak();
    send_ev(20, 20, 4);
    send_ev(22, 3, 3);
    repeat (10) tick();
    chk(exp_q.size() == 0, "R7 no early fire", exp_q.size(), 0);
    send_ev(20, 20, 4);
    send_ev(22, 3, 3);
    drain();

    // R9: walk stalls on full FIFO
    req = "R9 backpressure";
    bp_hold = 1'b1;
    fill_kernel(11, 8, 8, 0, 0, 7);
    for (int i = 0; i < 5; i++) send_ev(12, 12, 11);
    repeat (200) tick();
    @(negedge clk_i);
    chk(oe_valid_o == 1'b1, "R9 held valid", int'(oe_valid_o), 1);
    chk(ev_ready_o == 1'b0, "R9 input blocked", int'(ev_ready_o), 0);
    chk(exp_q.size() == 64, "R9 expected count", exp_q.size(), 64);
    tick();
    bp_hold = 1'b0;
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired in %s", req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule